// File: doc/BRIEF.md
# Intra 16x16 Luma Predictor (Vertical, Horizontal, DC)

This block builds a 16x16 block of unsigned 8-bit predicted pixels from the samples that border it: one row of 16 samples above the block and one column of 16 samples to its left. A single-cycle start pulse captures a 2-bit mode code, two flags that say whether the left and upper neighbours exist, and both neighbour vectors. The block then spends one cycle on accumulation and streams out the prediction, one full 16-pixel row per clock, marking the first and last row.

Three modes are served. Vertical repeats the upper row on every output row. Horizontal fills each output row with the left sample of the same row index. DC fills the whole block with one value. That value is a rounded mean of whichever neighbours are flagged present: the left column alone, the upper row alone, or both together with twice the divisor. With no neighbours the fill is mid-grey 128. The fourth mode code (plane) is refused with an error pulse.

Top module: `intra16_pred`

## Requirements
- R1: While reset is asserted and after it is released, busy, row_valid and mode_err are low.
- R2: A start pulse sampled while idle with mode 0, 1 or 2 raises busy on the next cycle. Row 0 appears one cycle after that. Rows 0 to 15 follow on consecutive cycles with row_valid high, and row_first is high only on row 0 and row_last only on row 15. busy falls in the cycle after row 15.
- R3: Mode 0 (vertical): every output row equals up_row. Pixel x of any row vector sits at bits [8x+7:8x].
- R4: Mode 1 (horizontal): output row y holds 16 copies of left sample y, which is bits [8y+7:8y] of left_col.
- R5: Mode 2 (DC) with only the left flag set: every pixel is (sum of the 16 left samples + 8) >> 4.
- R6: Mode 2 with only the upper flag set: every pixel is (sum of the 16 upper samples + 8) >> 4.
- R7: Mode 2 with both flags set: every pixel is (left sum + upper sum + 16) >> 5.
- R8: Mode 2 with neither flag set: every pixel is 128.
- R9: Mode 3 sampled with start while idle makes mode_err high for exactly one cycle. No row is produced and busy stays low.
- R10: A start pulse, and changes to mode, flags or neighbour inputs, while busy have no effect on the block in progress.
- R11: With all neighbour samples at 255 and both flags set, the DC fill is 255, so the sums do not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a block; sampled only while idle |
| mode | input | 2 | 0 vertical, 1 horizontal, 2 DC, 3 plane (refused) |
| avail_left | input | 1 | Left column is present |
| avail_up | input | 1 | Upper row is present |
| up_row | input | 128 | Upper neighbour samples, sample x at [8x+7:8x] |
| left_col | input | 128 | Left neighbour samples, sample y at [8y+7:8y] |
| busy | output | 1 | A block is being accumulated or emitted |
| row_valid | output | 1 | row_data holds a prediction row |
| row_first | output | 1 | Current row is row 0 |
| row_last | output | 1 | Current row is row 15 |
| row_data | output | 128 | Predicted row, pixel x at [8x+7:8x] |
| mode_err | output | 1 | One-cycle pulse: plane mode was requested |

## Verification
The assertions assume that the design clock is present and that reset is applied before the first start. They do not assume that start is quiet while busy, or that the neighbour inputs hold still after capture. The stimulus therefore deliberately breaks both conditions. In the cycle after every accepted start, it raises start again with a different mode and inverted neighbour vectors, and the rows that follow must still match the values captured at the first start. Neighbour patterns cover ramps, scattered values, all-ones and the rounding cases of each DC divisor.

// File: rtl/intra16_pkg.sv
package intra16_pkg;

   typedef enum logic [1:0] {
      PM_VERT  = 2'd0,
      PM_HORZ  = 2'd1,
      PM_DC    = 2'd2,
      PM_PLANE = 2'd3
   } pred_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_ACC  = 2'd1,
      ST_EMIT = 2'd2
   } ctl_state_e;

endpackage

// File: rtl/i16_sum_tree.sv
module i16_sum_tree #(
   parameter int N     = 16,
   parameter int W     = 8,
   parameter int SUM_W = W + $clog2(N)
) (
   input  logic [N*W-1:0]   samples_i,
   output logic [SUM_W-1:0] sum_o
);
   // heap-ordered binary tree: leaves at N..2N-1, root at 1
   logic [SUM_W-1:0] node [1:2*N-1];

   for (genvar k = 0; k < N; k++) begin : g_leaf
      assign node[N+k] = SUM_W'(samples_i[k*W +: W]);
   end

   for (genvar k = 1; k < N; k++) begin : g_add
      assign node[k] = node[2*k] + node[2*k+1];
   end

   assign sum_o = node[1];

   if (SUM_W < W + $clog2(N)) begin : g_bad_sum_w
      initial $fatal(1, "i16_sum_tree: SUM_W too narrow for N samples");
   end
endmodule

// File: rtl/i16_dc_calc.sv
module i16_dc_calc #(
   parameter int N     = 16,
   parameter int W     = 8,
   parameter int SUM_W = W + $clog2(N)
) (
   input  logic [SUM_W-1:0] sum_left_i,
   input  logic [SUM_W-1:0] sum_up_i,
   input  logic             have_left_i,
   input  logic             have_up_i,
   output logic [W-1:0]     dc_o
);
   localparam int LG = $clog2(N);
   localparam logic [SUM_W-1:0] RND1 = SUM_W'(N / 2);
   localparam logic [SUM_W:0]   RND2 = (SUM_W+1)'(N);
   localparam logic [W-1:0]     MID  = W'(1 << (W - 1));

   logic [SUM_W:0] both_sum;
   assign both_sum = {1'b0, sum_left_i} + {1'b0, sum_up_i};

   always_comb begin
      unique case ({have_left_i, have_up_i})
         2'b11:   dc_o = W'((both_sum + RND2) >> (LG + 1));
         2'b10:   dc_o = W'((sum_left_i + RND1) >> LG);
         2'b01:   dc_o = W'((sum_up_i + RND1) >> LG);
         default: dc_o = MID;
      endcase
   end
endmodule

// File: rtl/i16_row_gen.sv
module i16_row_gen
   import intra16_pkg::*;
#(
   parameter int N  = 16,
   parameter int W  = 8,
   parameter int LG = $clog2(N)
) (
   input  pred_mode_e      mode_i,
   input  logic [N*W-1:0]  up_i,
   input  logic [N*W-1:0]  left_i,
   input  logic [W-1:0]    dc_i,
   input  logic [LG-1:0]   row_i,
   output logic [N*W-1:0]  row_o
);
   logic [W-1:0] lft [N];
   logic [W-1:0] lsel;

   for (genvar k = 0; k < N; k++) begin : g_unpack
      assign lft[k] = left_i[k*W +: W];
   end

   assign lsel = lft[row_i];

   for (genvar x = 0; x < N; x++) begin : g_pix
      always_comb begin
         unique case (mode_i)
            PM_VERT: row_o[x*W +: W] = up_i[x*W +: W];
            PM_HORZ: row_o[x*W +: W] = lsel;
            default: row_o[x*W +: W] = dc_i;
         endcase
      end
   end
endmodule

// File: rtl/intra16_pred.sv
module intra16_pred
   import intra16_pkg::*;
#(
   parameter int N = 16,
   parameter int W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       mode,
   input  logic             avail_left,
   input  logic             avail_up,
   input  logic [N*W-1:0]   up_row,
   input  logic [N*W-1:0]   left_col,
   output logic             busy,
   output logic             row_valid,
   output logic             row_first,
   output logic             row_last,
   output logic [N*W-1:0]   row_data,
   output logic             mode_err
);
   localparam int LG    = $clog2(N);
   localparam int SUM_W = W + LG;
   localparam logic [LG-1:0] LAST_ROW = LG'(N - 1);

   if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
      initial $fatal(1, "intra16_pred: N must be a power of two >= 2");
   end
   if (W < 2) begin : g_bad_w
      initial $fatal(1, "intra16_pred: W must be at least 2");
   end

   ctl_state_e       st_q;
   pred_mode_e       mode_q;
   logic             al_q, au_q;
   logic [N*W-1:0]   up_q, left_q;
   logic [W-1:0]     dc_q, dc_next;
   logic [LG-1:0]    row_q;
   logic             err_q;
   logic [SUM_W-1:0] sum_l, sum_u;

   i16_sum_tree #(.N(N), .W(W), .SUM_W(SUM_W)) u_sum_left (
      .samples_i (left_q),
      .sum_o     (sum_l)
   );

   i16_sum_tree #(.N(N), .W(W), .SUM_W(SUM_W)) u_sum_up (
      .samples_i (up_q),
      .sum_o     (sum_u)
   );

   i16_dc_calc #(.N(N), .W(W), .SUM_W(SUM_W)) u_dc (
      .sum_left_i  (sum_l),
      .sum_up_i    (sum_u),
      .have_left_i (al_q),
      .have_up_i   (au_q),
      .dc_o        (dc_next)
   );

   i16_row_gen #(.N(N), .W(W), .LG(LG)) u_rows (
      .mode_i (mode_q),
      .up_i   (up_q),
      .left_i (left_q),
      .dc_i   (dc_q),
      .row_i  (row_q),
      .row_o  (row_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         mode_q <= PM_VERT;
         al_q   <= 1'b0;
         au_q   <= 1'b0;
         up_q   <= '0;
         left_q <= '0;
         dc_q   <= '0;
         row_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         err_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  if (pred_mode_e'(mode) == PM_PLANE) begin
                     err_q <= 1'b1;
                  end else begin
                     mode_q <= pred_mode_e'(mode);
                     al_q   <= avail_left;
                     au_q   <= avail_up;
                     up_q   <= up_row;
                     left_q <= left_col;
                     st_q   <= ST_ACC;
                  end
               end
            end
            ST_ACC: begin
               dc_q  <= dc_next;
               row_q <= '0;
               st_q  <= ST_EMIT;
            end
            ST_EMIT: begin
               if (row_q == LAST_ROW) st_q <= ST_IDLE;
               else                   row_q <= row_q + 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy      = (st_q != ST_IDLE);
   assign row_valid = (st_q == ST_EMIT);
   assign row_first = row_valid && (row_q == '0);
   assign row_last  = row_valid && (row_q == LAST_ROW);
   assign mode_err  = err_q;

   // R2
   busy_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !row_valid ##1 row_first);

   // R2
   rows_contig_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_valid && !row_last |=> row_valid && !row_first);

   // R2
   last_row_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_last |=> !busy);

   // R9
   err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |-> !busy && !row_valid);

   // R9
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_err |=> !mode_err);

   // R3 R10
   vert_rows_same_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_valid && !row_first && mode_q == PM_VERT |-> $stable(row_data));

   // R5 R6 R7 R8
   dc_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
      row_valid && mode_q == PM_DC |-> row_data == {N{row_data[W-1:0]}});

   // R10
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !row_last |=> busy);
endmodule

// File: tb/tb_intra16_pred.sv
module tb_intra16_pred;
   localparam int N = 16;
   localparam int W = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [1:0]     mode = 2'd0;
   logic           avail_left = 1'b0;
   logic           avail_up = 1'b0;
   logic [N*W-1:0] up_row = '0;
   logic [N*W-1:0] left_col = '0;
   logic           busy, row_valid, row_first, row_last, mode_err;
   logic [N*W-1:0] row_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [N*W-1:0] exp_q [$];
   logic [1:0]     mk_q  [$];
   string          req_q [$];

   always #5 clk = ~clk;

   intra16_pred #(.N(N), .W(W)) dut (
      .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
      .avail_left(avail_left), .avail_up(avail_up),
      .up_row(up_row), .left_col(left_col),
      .busy(busy), .row_valid(row_valid), .row_first(row_first),
      .row_last(row_last), .row_data(row_data), .mode_err(mode_err)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [N*W-1:0] act, input logic [N*W-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [N*W-1:0] pat(input int seed);
      logic [N*W-1:0] v;
      for (int i = 0; i < N; i++) v[i*W +: W] = W'(seed * 37 + i * i * 13 + seed * i + 5);
      return v;
   endfunction

   function automatic int dc_ref(input logic [N*W-1:0] up, input logic [N*W-1:0] lf,
                                 input bit al, input bit au);
      int su = 0;
      int sl = 0;
      for (int i = 0; i < N; i++) begin
         su += int'(up[i*W +: W]);
         sl += int'(lf[i*W +: W]);
      end
      if (al && au) return (sl + su + 16) >> 5;
      if (al)       return (sl + 8) >> 4;
      if (au)       return (su + 8) >> 4;
      return 128;
   endfunction

   // monitor: pops expected rows as the design produces them
   always @(negedge clk) begin
      if (rst_n && row_valid) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R2", "unexpected row", row_data, '0);
         end else begin
            logic [N*W-1:0] e;
            logic [1:0]     m;
            string          r;
            e = exp_q.pop_front();
            m = mk_q.pop_front();
            r = req_q.pop_front();
            chk(row_data == e, r, "row data", row_data, e);
            chk({row_first, row_last} == m, "R2", "first/last markers",
                N*W'({row_first, row_last}), N*W'(m));
         end
      end
   end

   task automatic run_block(input logic [1:0] md, input bit al, input bit au,
                            input logic [N*W-1:0] up, input logic [N*W-1:0] lf,
                            input string req);
      int dcv;
      logic [N*W-1:0] row;
      dcv = dc_ref(up, lf, al, au);
      for (int y = 0; y < N; y++) begin
         case (md)
            2'd0:    row = up;
            2'd1:    row = {N{lf[y*W +: W]}};
            default: row = {N{W'(dcv)}};
         endcase
         exp_q.push_back(row);
         mk_q.push_back({y == 0, y == N - 1});
         req_q.push_back(req);
      end
      @(negedge clk);
      start = 1'b1; mode = md; avail_left = al; avail_up = au;
      up_row = up; left_col = lf;
      @(negedge clk);
      chk(busy && !row_valid, "R2", "busy without row after start",
          N*W'({busy, row_valid}), N*W'(2'b10));
      // R10: disturb every input while busy
      start = 1'b1; mode = md ^ 2'd1; avail_left = !al; avail_up = !au;
      up_row = ~up; left_col = ~lf;
      @(negedge clk);
      start = 1'b0;
      repeat (16) @(negedge clk);
      chk(!busy && !row_valid, "R2", "idle after last row",
          N*W'({busy, row_valid}), '0);
      chk(exp_q.size() == 0, "R2", "rows outstanding", N*W'(exp_q.size()), '0);
      exp_q.delete(); mk_q.delete(); req_q.delete();
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL R2 watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [N*W-1:0] ramp;
      for (int i = 0; i < N; i++) ramp[i*W +: W] = W'(i * 16 + 3);
      repeat (3) @(negedge clk);
      chk(!busy && !row_valid && !mode_err, "R1", "outputs during reset",
          N*W'({busy, row_valid, mode_err}), '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !row_valid && !mode_err, "R1", "outputs after reset",
          N*W'({busy, row_valid, mode_err}), '0);

      run_block(2'd0, 1'b0, 1'b0, pat(3), pat(9), "R3");
      run_block(2'd0, 1'b1, 1'b1, ramp, pat(4), "R3");
      run_block(2'd1, 1'b1, 1'b1, pat(7), ramp, "R4");
      run_block(2'd1, 1'b0, 1'b0, pat(1), pat(11), "R4");
      run_block(2'd2, 1'b1, 1'b0, pat(5), pat(12), "R5");
      run_block(2'd2, 1'b1, 1'b0, pat(5), {N{8'd0}} | 128'd8, "R5");
      run_block(2'd2, 1'b0, 1'b1, pat(13), pat(6), "R6");
      run_block(2'd2, 1'b0, 1'b1, {{(N-1){8'd0}}, 8'd7}, pat(6), "R6");
      run_block(2'd2, 1'b1, 1'b1, pat(21), pat(8), "R7");
      run_block(2'd2, 1'b1, 1'b1, {{(N-1){8'd0}}, 8'd16}, '0, "R7");
      run_block(2'd2, 1'b0, 1'b0, pat(2), pat(15), "R8");
      run_block(2'd2, 1'b1, 1'b1, {N{8'hFF}}, {N{8'hFF}}, "R11");

      // R9: plane mode refused
      @(negedge clk);
      start = 1'b1; mode = 2'd3; avail_left = 1'b1; avail_up = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(mode_err && !busy && !row_valid, "R9", "error pulse, idle",
          N*W'({mode_err, busy, row_valid}), N*W'(3'b100));
      @(negedge clk);
      chk(!mode_err && !busy, "R9", "error pulse ends",
          N*W'({mode_err, busy}), '0);
      repeat (4) @(negedge clk);
      chk(!busy && !row_valid, "R9", "no rows after plane request",
          N*W'({busy, row_valid}), '0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule